// File: doc/BRIEF.md
# 4:3 Polyphase Interpolating Resampler

This block raises the sample rate of one line of video by a factor of four over three. Every accepted input sample passes through a four-tap FIR whose taps change from output to output. Four phases of four taps make up sixteen signed coefficients, and software writes them. A coefficient write lands in a shadow set. A one-shot trigger arms a copy of the shadow set into the working set. The copy happens at the next line start, so a reload never disturbs a line that is already being filtered.

A peaking stage follows the interpolator and can partly restore high frequencies. It has three settings: off, a mild boost or a strong boost. Normally only samples inside the window flagged by the line timing are filtered. A baseband mode accepts every sample of the line, including data bursts and blanking. A compatible 4:3 stretch of 523 samples comes out as 697 samples. A stretch of 262 samples becomes 349.

Top module: `interp43_resampler`

## Requirements
- R1: After reset `outValid` is low and `outSample` is 0. Both coefficient sets hold a pass-through filter: the tap-0 coefficient of every phase is 64 and every other coefficient is 0.
- R2: Output phases run 0,1,2,3,0,... and each accepted sample yields one output. After an output of phase 3, an extra phase-0 output follows on the next cycle from the same samples. Line start returns the phase to 0. A line of N accepted samples therefore yields floor(4(N-1)/3)+1 outputs (523 gives 697, 262 gives 349).
- R3: Each output is y = clamp(floor((S + 32) / 64), 0, 255), where S = sum over tap t of C[4p+t]·x[n-t]. Here p is the phase, C is the two's-complement 8-bit coefficient written at `coefAddr` = 4p+t, and x[n] is the newest unsigned sample. Samples from before the line start count as 0.
- R4: The output for an accepted sample is valid two cycles after the cycle that presents it. The extra phase-0 output comes one cycle after that.
- R5: Writes to the shadow set change nothing at the output until a trigger is given.
- R6: A `coefLoad` pulse arms a copy of the shadow set into the working set at the next `lineStart`. A line already in progress keeps its old coefficients. A pulse in the same cycle as `lineStart` takes effect at the following line start.
- R7: Take y from R3 and d = y minus the previous y of the line. `peakMode` 00 gives y. Mode 01 gives clamp(y + floor(d/2)). Modes 10 and 11 give clamp(y + d). The clamp is to 0..255, and d is 0 for the first output of a line.
- R8: When `basebandEn` is 0, a sample is accepted only when `activeWin` is 1. Other samples produce no output and do not enter the taps. When `basebandEn` is 1, every valid sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineStart | input | 1 | One-cycle pulse before the first sample of a line |
| activeWin | input | 1 | Marks samples inside the filtered window |
| basebandEn | input | 1 | Filters the whole line regardless of `activeWin` |
| inValid | input | 1 | Input sample strobe, at most every other cycle |
| inSample | input | 8 | Unsigned input sample |
| coefWe | input | 1 | Shadow coefficient write strobe |
| coefAddr | input | 4 | Shadow coefficient index, 4·phase + tap |
| coefData | input | 8 | Signed coefficient, 64 = unity |
| coefLoad | input | 1 | One-shot trigger arming the shadow-to-working copy |
| peakMode | input | 2 | 00 off, 01 low boost, 10/11 high boost |
| outValid | output | 1 | Output sample strobe |
| outSample | output | 8 | Unsigned resampled and peaked sample |

## Verification
An accepted sample presented in cycle t produces an output that is valid in cycle t+2. When that sample takes phase 3, a second output is valid in cycle t+3. The bench counts clock edges, records for every expected output the edge after which it must appear, and tags every observed output with the edge count seen on the falling edge. Value and arrival edge are then compared pairwise per line. Coefficient swaps take effect only at line starts, and peaking uses the previous output of the same line. For this reason the reference model tracks shadow, working and armed state at the same edges as the hardware.

// File: rtl/interp43_pkg.sv
package interp43_pkg;
  localparam int PHASES  = 4;
  localparam int TAPS    = 4;
  localparam int PH_W    = $clog2(PHASES);
  localparam int TAP_W   = $clog2(TAPS);
  localparam int NCOEF   = PHASES * TAPS;
  localparam int CADDR_W = PH_W + TAP_W;

  typedef struct packed {
    logic            clearLine;
    logic            shiftIn;
    logic            swapCoef;
    logic            fire;
    logic            useNew;
    logic            first;
    logic [PH_W-1:0] phase;
  } ctlStrobes_t;
endpackage

// File: rtl/interp43_ctrl.sv
module interp43_ctrl
  import interp43_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineStart,
  input  logic        activeWin,
  input  logic        basebandEn,
  input  logic        inValid,
  input  logic        coefLoad,
  output ctlStrobes_t ctl
);
  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] phBase;
  logic            pend;
  logic            armed;
  logic            firstFlag;
  logic            accept;

  assign accept = inValid & (activeWin | basebandEn);
  assign phBase = lineStart ? '0 : ph;

  always_comb begin
    ctl.clearLine = lineStart;
    ctl.shiftIn   = accept;
    ctl.swapCoef  = lineStart & armed;
    ctl.fire      = accept | pend;
    ctl.useNew    = accept;
    ctl.first     = accept & (firstFlag | lineStart);
    ctl.phase     = accept ? phBase : ph;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph        <= '0;
      pend      <= 1'b0;
      armed     <= 1'b0;
      firstFlag <= 1'b1;
    end else begin
      armed <= coefLoad | (armed & ~lineStart);
      pend  <= accept & (phBase == PH_W'(PHASES - 1));
      if (accept)         firstFlag <= 1'b0;
      else if (lineStart) firstFlag <= 1'b1;
      if (accept)         ph <= phBase + 1'b1;
      else if (lineStart) ph <= '0;
      else if (pend)      ph <= ph + 1'b1;
    end
  end
endmodule

// File: rtl/interp43_datapath.sv
module interp43_datapath
  import interp43_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int FRAC   = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobes_t              ctl,
  input  logic [DATA_W-1:0]        inSample,
  input  logic                     coefWe,
  input  logic [CADDR_W-1:0]       coefAddr,
  input  logic signed [COEF_W-1:0] coefData,
  input  logic [1:0]               peakMode,
  output logic                     outValid,
  output logic [DATA_W-1:0]        outSample
);
  localparam int PROD_W = DATA_W + 1 + COEF_W;
  localparam int ACC_W  = PROD_W + TAP_W;
  localparam int PK_W   = DATA_W + 2;
  localparam int ONE    = 1 << FRAC;
  localparam int HALF   = 1 << (FRAC - 1);

  logic [DATA_W-1:0]        dly    [TAPS];
  logic [DATA_W-1:0]        tapVal [TAPS];
  logic signed [COEF_W-1:0] coefAct[NCOEF];
  logic signed [COEF_W-1:0] coefShd[NCOEF];
  logic signed [PROD_W-1:0] prod   [TAPS];
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  rnd;
  logic                     yValid, yFirst;
  logic [DATA_W-1:0]        y, yPrev;
  logic signed [DATA_W:0]   diff, boost;
  logic signed [PK_W-1:0]   pk;

  function automatic logic [DATA_W-1:0] satAcc(input logic signed [ACC_W-1:0] v);
    if (v[ACC_W-1])                return '0;
    else if (|v[ACC_W-2:DATA_W])   return '1;
    else                           return v[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] satPk(input logic signed [PK_W-1:0] v);
    if (v[PK_W-1])       return '0;
    else if (v[PK_W-2])  return '1;
    else                 return v[DATA_W-1:0];
  endfunction

  // taps seen by the MAC: the incoming sample joins combinationally
  always_comb begin
    for (int t = 0; t < TAPS; t++) tapVal[t] = dly[t];
    if (ctl.useNew) begin
      tapVal[0] = inSample;
      for (int t = 1; t < TAPS; t++) tapVal[t] = ctl.clearLine ? '0 : dly[t-1];
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    logic [CADDR_W-1:0] cIdx;
    assign cIdx    = {ctl.phase, TAP_W'(t)};
    assign prod[t] = $signed({1'b0, tapVal[t]}) * coefAct[cIdx];
  end

  always_comb begin
    acc = '0;
    for (int t = 0; t < TAPS; t++) acc = acc + ACC_W'(prod[t]);
    rnd = (acc + $signed(ACC_W'(HALF))) >>> FRAC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < TAPS; t++) dly[t] <= '0;
    end else if (ctl.shiftIn) begin
      dly[0] <= inSample;
      for (int t = 1; t < TAPS; t++) dly[t] <= ctl.clearLine ? '0 : dly[t-1];
    end else if (ctl.clearLine) begin
      for (int t = 0; t < TAPS; t++) dly[t] <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NCOEF; i++) begin
        if (i % TAPS == 0) begin
          coefAct[i] <= COEF_W'(ONE);
          coefShd[i] <= COEF_W'(ONE);
        end else begin
          coefAct[i] <= '0;
          coefShd[i] <= '0;
        end
      end
    end else begin
      if (coefWe) coefShd[coefAddr] <= coefData;
      if (ctl.swapCoef)
        for (int i = 0; i < NCOEF; i++) coefAct[i] <= coefShd[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      yValid <= 1'b0;
      yFirst <= 1'b0;
      y      <= '0;
    end else begin
      yValid <= ctl.fire;
      if (ctl.fire) begin
        y      <= satAcc(rnd);
        yFirst <= ctl.first;
      end
    end
  end

  always_comb begin
    diff = $signed({1'b0, y}) - $signed({1'b0, yPrev});
    if (yFirst)            boost = '0;
    else if (peakMode[1])  boost = diff;
    else if (peakMode[0])  boost = diff >>> 1;
    else                   boost = '0;
    pk = $signed({2'b00, y}) + PK_W'(boost);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outSample <= '0;
      yPrev     <= '0;
    end else begin
      outValid <= yValid;
      if (yValid) begin
        outSample <= satPk(pk);
        yPrev     <= y;
      end
    end
  end
endmodule

// File: rtl/interp43_resampler.sv
module interp43_resampler
  import interp43_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int FRAC   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lineStart,
  input  logic               activeWin,
  input  logic               basebandEn,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  inSample,
  input  logic               coefWe,
  input  logic [CADDR_W-1:0] coefAddr,
  input  logic [COEF_W-1:0]  coefData,
  input  logic               coefLoad,
  input  logic [1:0]         peakMode,
  output logic               outValid,
  output logic [DATA_W-1:0]  outSample
);
  ctlStrobes_t ctl;

  interp43_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lineStart  (lineStart),
    .activeWin  (activeWin),
    .basebandEn (basebandEn),
    .inValid    (inValid),
    .coefLoad   (coefLoad),
    .ctl        (ctl)
  );

  interp43_datapath #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .FRAC   (FRAC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .inSample  (inSample),
    .coefWe    (coefWe),
    .coefAddr  (coefAddr),
    .coefData  ($signed(coefData)),
    .peakMode  (peakMode),
    .outValid  (outValid),
    .outSample (outSample)
  );
endmodule

// File: rtl/interp43_checker.sv
module interp43_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              activeWin,
  input logic              basebandEn,
  input logic              outValid,
  input logic [DATA_W-1:0] outSample
);
  logic acc;
  assign acc = inValid & (activeWin | basebandEn);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && outSample == '0));

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(acc, 2) |-> outValid);

  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(acc, 2) && !$past(acc, 3)) |-> !outValid);

  // R2
  burst_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && $past(outValid) && $past(outValid, 2) && $past(outValid, 3)));
endmodule

bind interp43_resampler interp43_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .activeWin  (activeWin),
  .basebandEn (basebandEn),
  .outValid   (outValid),
  .outSample  (outSample)
);

// File: tb/interp43_resampler_test.sv
module interp43_resampler_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineStart = 1'b0, activeWin = 1'b0, basebandEn = 1'b0;
  logic       inValid = 1'b0, coefWe = 1'b0, coefLoad = 1'b0;
  logic [7:0] inSample = '0, coefData = '0;
  logic [3:0] coefAddr = '0;
  logic [1:0] peakMode = '0;
  logic       outValid;
  logic [7:0] outSample;

  interp43_resampler uut (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .activeWin(activeWin),
    .basebandEn(basebandEn), .inValid(inValid), .inSample(inSample),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .coefLoad(coefLoad), .peakMode(peakMode), .outValid(outValid),
    .outSample(outSample)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int gotV[$], gotC[$], expV[$], expC[$];
  int nChk = 0, nFail = 0;

  always @(negedge clk)
    if (rstN && outValid) begin
      gotV.push_back(int'(outSample));
      gotC.push_back(cyc);
    end

  // reference model state
  int mAct[16], mSh[16], mTap[4];
  int mPh = 0, mPrev = 0, pkM = 0;
  bit mArmed = 0, mFirst = 1, bbM = 0;

  function automatic int sat8(int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  function automatic int modelY(int ph);
    int s = 0;
    for (int t = 0; t < 4; t++) s += mAct[ph * 4 + t] * mTap[t];
    return sat8((s + 32) >>> 6);
  endfunction

  function automatic int modelPk(int yv, bit first);
    int d = yv - mPrev;
    int b = 0;
    if (!first) begin
      if (pkM >= 2) b = d;
      else if (pkM == 1) b = d >>> 1;
    end
    mPrev = yv;
    return sat8(yv + b);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCoef(int a, int v);
    coefWe = 1'b1; coefAddr = 4'(a); coefData = 8'(v);
    mSh[a] = v;
    @(negedge clk);
    coefWe = 1'b0;
  endtask

  task automatic trigger();
    coefLoad = 1'b1; mArmed = 1;
    @(negedge clk);
    coefLoad = 1'b0;
  endtask

  task automatic startLine(bit trig);
    lineStart = 1'b1; coefLoad = trig;
    if (mArmed) for (int i = 0; i < 16; i++) mAct[i] = mSh[i];
    mArmed = trig;
    for (int t = 0; t < 4; t++) mTap[t] = 0;
    mPh = 0; mFirst = 1;
    @(negedge clk);
    lineStart = 1'b0; coefLoad = 1'b0;
  endtask

  task automatic sendSample(int x, bit win, int gap);
    int k;
    int yv;
    inValid = 1'b1; inSample = 8'(x); activeWin = win;
    k = cyc + 1;
    if (win || bbM) begin
      for (int t = 3; t > 0; t--) mTap[t] = mTap[t-1];
      mTap[0] = x;
      yv = modelY(mPh);
      expV.push_back(modelPk(yv, mFirst)); expC.push_back(k + 1);
      mFirst = 0;
      if (mPh == 3) begin
        yv = modelY(0);
        expV.push_back(modelPk(yv, 0)); expC.push_back(k + 2);
        mPh = 1;
      end else mPh++;
    end
    @(negedge clk);
    inValid = 1'b0; activeWin = 1'b0;
    idle(gap);
  endtask

  task automatic checkLine(string req, int wantCount);
    int badV = -1, badC = -1;
    idle(5);
    if (wantCount >= 0) chk(gotV.size() == wantCount, req, "output count", gotV.size(), wantCount);
    chk(gotV.size() == expV.size(), req, "outputs vs model count", gotV.size(), expV.size());
    for (int i = 0; i < gotV.size() && i < expV.size(); i++) begin
      if (badV < 0 && gotV[i] != expV[i]) badV = i;
      if (badC < 0 && gotC[i] != expC[i]) badC = i;
    end
    chk(badV < 0, req, "sample value", badV < 0 ? 0 : gotV[badV], badV < 0 ? 0 : expV[badV]);
    chk(badC < 0, req, "arrival edge", badC < 0 ? 0 : gotC[badC], badC < 0 ? 0 : expC[badC]);
    gotV.delete(); gotC.delete(); expV.delete(); expC.delete();
  endtask

  // winMode 0: always in window, 1: random window
  task automatic runLine(int n, int winMode, bit fast, string req, int wantCount);
    startLine(0);
    for (int i = 0; i < n; i++)
      sendSample(int'($urandom % 256), winMode == 0 ? 1'b1 : 1'($urandom % 2),
                 fast ? 1 : 1 + int'($urandom % 3));
    checkLine(req, wantCount);
  endtask

  task automatic loadCoefs(int kind);
    for (int a = 0; a < 16; a++) begin
      int v;
      case (kind)
        0: v = int'($urandom % 256) - 128;
        1: v = (a % 4 == 0) ? 64 - 16 * (a / 4) : (a % 4 == 1) ? 16 * (a / 4)
                            : int'($urandom % 17) - 8;
        2: v = 127;
        default: v = -128;
      endcase
      writeCoef(a, v);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(0, "watchdog", "run did not finish", cyc, WATCHDOG);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4307));
    for (int i = 0; i < 16; i++) begin
      mAct[i] = (i % 4 == 0) ? 64 : 0;
      mSh[i]  = mAct[i];
    end
    idle(3);
    // R1: reset values
    chk(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    chk(outSample == 8'd0, "R1", "outSample in reset", int'(outSample), 0);
    rstN = 1'b1;
    idle(2);
    chk(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);

    // R1 R2 R3 R4: pass-through default coefficients, 40 samples -> 53 outputs
    runLine(40, 0, 0, "R1", 53);
    runLine(31, 0, 1, "R4", 41);

    // R5: shadow writes without a trigger leave the output untouched
    loadCoefs(0);
    runLine(30, 0, 0, "R5", 39);

    // R6: trigger mid-line keeps old set for that line, new set next line
    startLine(0);
    for (int i = 0; i < 15; i++) sendSample(int'($urandom % 256), 1, 1 + int'($urandom % 2));
    trigger();
    for (int i = 0; i < 15; i++) sendSample(int'($urandom % 256), 1, 1 + int'($urandom % 2));
    checkLine("R6", 39);
    runLine(30, 0, 0, "R6", 39);

    // R6: trigger in the same cycle as line start waits one more line
    loadCoefs(1);
    startLine(1);
    for (int i = 0; i < 20; i++) sendSample(int'($urandom % 256), 1, 1);
    checkLine("R6", 26);
    runLine(20, 0, 0, "R6", 26);

    // R2: full luma and chroma stretches
    runLine(523, 0, 1, "R2", 697);
    runLine(262, 0, 0, "R2", 349);

    // R3: random coefficients with saturation in both directions
    loadCoefs(0); startLine(1);
    runLine(60, 0, 0, "R3", -1);
    loadCoefs(2); startLine(1);
    runLine(25, 0, 1, "R3", -1);
    loadCoefs(3); startLine(1);
    runLine(25, 0, 0, "R3", -1);

    // R7: peaking modes with realistic coefficients
    loadCoefs(1); startLine(1);
    for (int m = 0; m < 4; m++) begin
      peakMode = 2'(m); pkM = m;
      runLine(45, 0, m[0], "R7", 59);
    end
    peakMode = 2'd0; pkM = 0;

    // R8: window gating, then baseband mode accepting everything
    runLine(50, 1, 0, "R8", -1);
    basebandEn = 1'b1; bbM = 1;
    startLine(0);
    for (int i = 0; i < 25; i++) sendSample(int'($urandom % 256), 0, 1);
    checkLine("R8", 33);
    basebandEn = 1'b0; bbM = 0;
    startLine(0);
    for (int i = 0; i < 10; i++) sendSample(int'($urandom % 256), 0, 1);
    checkLine("R8", 0);

    summary();
    $finish;
  end
endmodule